// File: doc/BRIEF.md
# Per-Event Trailer Completion Tracker

This block decides when every required front-end source has closed out a given event. Each source ends its data for an event with a trailer that carries the source index and the event number. The tracker keeps a small two-dimensional flag store. A row is chosen by the low four bits of the event number, and a column by the source index. Each accepted trailer sets one flag.

The tracker follows one expected event number at a time. Once every source selected by a programmable mask has flagged the row of that event, the block offers the event number and a snapshot of the whole row to a downstream collector on a valid/ready pair. When the collector takes the offer, that row is wiped and the expected number steps forward, wrapping at 4096.

Trailers that repeat a flag, that point past the source range, or that fall outside the sixteen-event window are reported on single-cycle error pulses. A programmable watchdog reports a partly filled row that stalls too long, and names the sources still missing.

Top module: `evt_done_tracker`

## Requirements
- R1: After reset, `done_valid`, `err_dup`, `err_range` and `err_miss` are low, and the first event offered is number 0.
- R2: A trailer with source index s < NUM_SRC and event number e inside the window sets column s of row e[3:0]. The flag appears in the `done_row` snapshot of that event.
- R3: When every bit of `need_mask` is set in the row of the expected event, `done_valid` rises one cycle after the completing trailer is captured. `done_evt` then equals the expected number, and `done_row` holds the full row (bit i = source i), including sources outside the mask.
- R4: Trailers for later events in the window are stored, but events are offered strictly in expected order. A later row that is already full is offered in the cycle after the earlier one is taken.
- R5: While `done_valid` is high and `done_ready` is low, `done_valid`, `done_evt` and `done_row` hold their values.
- R6: A cycle with `done_valid` and `done_ready` both high clears the offered row and advances the expected number by one, modulo 4096 (4095 is followed by 0).
- R7: A trailer whose flag is already set pulses `err_dup` in the next cycle and leaves the row unchanged.
- R8: A trailer aimed at the row that is being offered (while `done_valid` is high) pulses `err_dup` and is not stored.
- R9: A trailer with source index >= NUM_SRC, or with an event number outside expected..expected+15 (modulo 4096), pulses `err_range` in the next cycle and stores nothing.
- R10: With `need_mask` all zero, no event is offered.
- R11: With `tmo_limit` = L > 0, the first trailer in the expected row starts a count while the row is incomplete. In the L-th cycle after that trailer is captured, `err_miss` pulses once for that event, and `miss_row` = `need_mask` & ~row. With L = 0, no such pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trl_valid | input | 1 | A trailer is present this cycle |
| trl_src | input | SRC_W (5) | Source index of the trailer |
| trl_evt | input | EVT_W (12) | Event number carried by the trailer |
| need_mask | input | NUM_SRC (18) | Sources that must report before an event is complete |
| tmo_limit | input | TMO_W (16) | Stall limit in cycles; 0 disables |
| done_valid | output | 1 | A completed event is offered |
| done_ready | input | 1 | Collector takes the offer |
| done_evt | output | EVT_W (12) | Number of the offered event |
| done_row | output | NUM_SRC (18) | Row snapshot of the offered event |
| err_dup | output | 1 | Repeated or locked-row trailer pulse |
| err_range | output | 1 | Source or event out of range pulse |
| err_miss | output | 1 | Stall pulse for the expected event |
| miss_row | output | NUM_SRC (18) | Sources still absent at the last stall pulse |

## Verification
The assertions assume that at most one trailer arrives per cycle, and that `tmo_limit` is not changed while a row is partly filled. They also assume the collector does not expect the offered snapshot to change between offer and take. The stimulus drives all inputs on the falling edge and presents one trailer per call. It alters the mask and the stall limit only while no event is offered and the stall counter is idle. Every repeated or out-of-window trailer is sent deliberately, and the block's own response to it is checked.

// File: rtl/evt_trk_pkg.sv
package evt_trk_pkg;

  localparam int SRC_MAX = 64;
  typedef logic [SRC_MAX-1:0] srcvec_t;

  typedef enum logic {HS_IDLE, HS_OFFER} hs_state_t;

  // true when every required source has flagged the row
  function automatic logic row_full(srcvec_t bits, srcvec_t need);
    return (need != '0) && ((bits & need) == need);
  endfunction

  // required sources not yet flagged
  function automatic srcvec_t row_gap(srcvec_t bits, srcvec_t need);
    return need & ~bits;
  endfunction

endpackage

// File: rtl/evt_bit_matrix.sv
module evt_bit_matrix #(
  parameter int NUM_SRC = 18,
  parameter int ROW_W   = 4,
  parameter int SRC_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [SRC_W-1:0]   in_src,
  input  logic [ROW_W-1:0]   in_row,
  input  logic               win_ok,
  input  logic               lock_on,
  input  logic [ROW_W-1:0]   lock_row,
  input  logic               clr_on,
  input  logic [ROW_W-1:0]   clr_row,
  input  logic [ROW_W-1:0]   look_row,
  output logic [NUM_SRC-1:0] look_bits,
  output logic               set_fire,
  output logic               err_dup_q,
  output logic               err_range_q
);
  localparam int ROWS = 1 << ROW_W;

  logic [NUM_SRC-1:0] mtx_q [ROWS];
  logic               src_ok;
  logic [NUM_SRC-1:0] onehot;
  logic [NUM_SRC-1:0] hit_bits;
  logic               dup_fire;
  logic               range_fire;

  assign src_ok     = 32'(in_src) < 32'(NUM_SRC);
  assign onehot     = src_ok ? (NUM_SRC'(1) << in_src) : '0;
  assign hit_bits   = mtx_q[in_row];
  assign range_fire = in_valid && !(src_ok && win_ok);
  assign dup_fire   = in_valid && src_ok && win_ok &&
                      (((hit_bits & onehot) != '0) || (lock_on && (in_row == lock_row)));
  assign set_fire   = in_valid && src_ok && win_ok && !dup_fire;
  assign look_bits  = mtx_q[look_row];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mtx_q[r] <= '0;
      err_dup_q   <= 1'b0;
      err_range_q <= 1'b0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (clr_on && (clr_row == ROW_W'(r)))
          mtx_q[r] <= '0;
        else if (set_fire && (in_row == ROW_W'(r)))
          mtx_q[r] <= mtx_q[r] | onehot;
      end
      err_dup_q   <= dup_fire;
      err_range_q <= range_fire;
    end
  end

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_fire |=> mtx_q[$past(in_row)][$past(in_src)]); // R2
  AST_DUP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dup_fire && !(clr_on && clr_row == in_row)) |=> (mtx_q[$past(in_row)] == $past(hit_bits))); // R7
  AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_on && set_fire && (clr_row == in_row))); // R8
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_dup_q, err_range_q})); // R9

endmodule

// File: rtl/evt_handoff.sv
module evt_handoff #(
  parameter int NUM_SRC = 18,
  parameter int EVT_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] exp_bits,
  input  logic [NUM_SRC-1:0] need_mask,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [EVT_W-1:0]   out_evt,
  output logic [NUM_SRC-1:0] out_bits,
  output logic [EVT_W-1:0]   exp_evt,
  output logic               take
);
  import evt_trk_pkg::*;

  hs_state_t state_q;
  logic      full;

  assign full      = row_full(srcvec_t'(exp_bits), srcvec_t'(need_mask));
  assign out_valid = (state_q == HS_OFFER);
  assign take      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= HS_IDLE;
      exp_evt  <= '0;
      out_evt  <= '0;
      out_bits <= '0;
    end else begin
      case (state_q)
        HS_IDLE: if (full) begin
          state_q  <= HS_OFFER;
          out_evt  <= exp_evt;
          out_bits <= exp_bits;
        end
        HS_OFFER: if (out_ready) begin
          state_q <= HS_IDLE;
          exp_evt <= exp_evt + EVT_W'(1);
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_evt) && $stable(out_bits))); // R5
  AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (exp_evt == $past(out_evt) + EVT_W'(1))); // R6
  AST_OFFER_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_bits != '0)); // R3

endmodule

// File: rtl/evt_timeout.sv
module evt_timeout #(
  parameter int NUM_SRC = 18,
  parameter int TMO_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] exp_bits,
  input  logic [NUM_SRC-1:0] need_mask,
  input  logic [TMO_W-1:0]   limit,
  input  logic               busy,
  input  logic               advance,
  output logic               miss_pulse,
  output logic [NUM_SRC-1:0] miss_bits
);
  import evt_trk_pkg::*;

  logic [TMO_W-1:0] cnt_q;
  logic             fired_q;
  logic             armed;

  assign armed = (exp_bits != '0) && !busy && (limit != '0) &&
                 !row_full(srcvec_t'(exp_bits), srcvec_t'(need_mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      fired_q    <= 1'b0;
      miss_pulse <= 1'b0;
      miss_bits  <= '0;
    end else begin
      miss_pulse <= 1'b0;
      if (advance) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else if (armed) begin
        if (cnt_q < limit) cnt_q <= cnt_q + TMO_W'(1);
        if (!fired_q && (cnt_q == limit - TMO_W'(1))) begin
          miss_pulse <= 1'b1;
          miss_bits  <= NUM_SRC'(row_gap(srcvec_t'(exp_bits), srcvec_t'(need_mask)));
          fired_q    <= 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  AST_MISS_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    miss_pulse |=> !miss_pulse); // R11
  AST_MISS_NAMES: assert property (@(posedge clk) disable iff (!rst_n)
    miss_pulse |-> (miss_bits != '0)); // R11

endmodule

// File: rtl/evt_done_tracker.sv
module evt_done_tracker #(
  parameter int NUM_SRC = 18,
  parameter int EVT_W   = 12,
  parameter int ROW_W   = 4,
  parameter int TMO_W   = 16,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trl_valid,
  input  logic [SRC_W-1:0]   trl_src,
  input  logic [EVT_W-1:0]   trl_evt,
  input  logic [NUM_SRC-1:0] need_mask,
  input  logic [TMO_W-1:0]   tmo_limit,
  output logic               done_valid,
  input  logic               done_ready,
  output logic [EVT_W-1:0]   done_evt,
  output logic [NUM_SRC-1:0] done_row,
  output logic               err_dup,
  output logic               err_range,
  output logic               err_miss,
  output logic [NUM_SRC-1:0] miss_row
);
  localparam int ROWS = 1 << ROW_W;

  logic [EVT_W-1:0]   exp_evt;
  logic [EVT_W-1:0]   evt_dist;
  logic               win_ok;
  logic [NUM_SRC-1:0] exp_bits;
  logic               take;
  logic               set_fire;

  assign evt_dist = trl_evt - exp_evt;
  assign win_ok   = 32'(evt_dist) < 32'(ROWS);

  evt_bit_matrix #(.NUM_SRC(NUM_SRC), .ROW_W(ROW_W), .SRC_W(SRC_W)) u_matrix (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (trl_valid),
    .in_src     (trl_src),
    .in_row     (trl_evt[ROW_W-1:0]),
    .win_ok     (win_ok),
    .lock_on    (done_valid),
    .lock_row   (exp_evt[ROW_W-1:0]),
    .clr_on     (take),
    .clr_row    (exp_evt[ROW_W-1:0]),
    .look_row   (exp_evt[ROW_W-1:0]),
    .look_bits  (exp_bits),
    .set_fire   (set_fire),
    .err_dup_q  (err_dup),
    .err_range_q(err_range)
  );

  evt_handoff #(.NUM_SRC(NUM_SRC), .EVT_W(EVT_W)) u_handoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .exp_bits (exp_bits),
    .need_mask(need_mask),
    .out_ready(done_ready),
    .out_valid(done_valid),
    .out_evt  (done_evt),
    .out_bits (done_row),
    .exp_evt  (exp_evt),
    .take     (take)
  );

  evt_timeout #(.NUM_SRC(NUM_SRC), .TMO_W(TMO_W)) u_timeout (
    .clk       (clk),
    .rst_n     (rst_n),
    .exp_bits  (exp_bits),
    .need_mask (need_mask),
    .limit     (tmo_limit),
    .busy      (done_valid),
    .advance   (take),
    .miss_pulse(err_miss),
    .miss_bits (miss_row)
  );

  AST_MISS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_miss |-> !done_valid); // R11
  AST_RANGE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (trl_valid && !win_ok) |-> !set_fire); // R9

endmodule

// File: tb/evt_done_tracker_tb.sv
module evt_done_tracker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 18;
  localparam logic [NSRC-1:0] MASK3 = NSRC'((1 << 0) | (1 << 5) | (1 << 17));

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trl_valid = 1'b0;
  logic [4:0]      trl_src = '0;
  logic [11:0]     trl_evt = '0;
  logic [NSRC-1:0] need_mask = '0;
  logic [15:0]     tmo_limit = '0;
  logic            done_ready = 1'b0;
  logic            done_valid;
  logic [11:0]     done_evt;
  logic [NSRC-1:0] done_row;
  logic            err_dup, err_range, err_miss;
  logic [NSRC-1:0] miss_row;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_done_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .trl_valid(trl_valid), .trl_src(trl_src),
    .trl_evt(trl_evt), .need_mask(need_mask), .tmo_limit(tmo_limit),
    .done_valid(done_valid), .done_ready(done_ready), .done_evt(done_evt),
    .done_row(done_row), .err_dup(err_dup), .err_range(err_range),
    .err_miss(err_miss), .miss_row(miss_row)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input int src, input int evt);
    @(negedge clk);
    trl_valid = 1'b1;
    trl_src   = 5'(src);
    trl_evt   = 12'(evt);
    @(negedge clk);
    trl_valid = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk);
    done_ready = 1'b1;
    @(negedge clk);
    done_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(!done_valid && !err_dup && !err_range && !err_miss, "R1 reset outputs",
        {done_valid, err_dup, err_range, err_miss}, 0);
  endtask

  task automatic t_basic();
    need_mask = MASK3;
    send(5, 0);
    send(0, 0);
    send(9, 0);
    @(negedge clk);
    chk(!done_valid, "R3 incomplete row not offered", done_valid, 0);
    send(17, 0);
    chk(!done_valid, "R3 offer one cycle later", done_valid, 0);
    @(negedge clk);
    chk(done_valid && done_evt == 0, "R1 R3 first event is 0", done_evt, 0);
    chk(done_row == (MASK3 | NSRC'(1 << 9)), "R2 R3 row snapshot", done_row, MASK3 | NSRC'(1 << 9));
  endtask

  task automatic t_hold();
    logic [NSRC-1:0] row0;
    row0 = done_row;
    send(3, 0);
    chk(err_dup && !err_range, "R8 trailer into offered row", {err_dup, err_range}, 2'b10);
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk(done_valid && done_evt == 0 && done_row == row0, "R5 R8 offer held", done_row, row0);
    accept();
    chk(!done_valid, "R6 offer taken", done_valid, 0);
  endtask

  task automatic t_order();
    send(0, 2); send(5, 2); send(17, 2);
    @(negedge clk);
    chk(!done_valid, "R4 later event waits", done_valid, 0);
    send(0, 1); send(5, 1); send(17, 1);
    @(negedge clk);
    chk(done_valid && done_evt == 1 && done_row == MASK3, "R4 R6 event 1 offered", done_evt, 1);
    accept();
    @(negedge clk);
    chk(done_valid && done_evt == 2 && done_row == MASK3, "R4 event 2 follows", done_evt, 2);
    accept();
  endtask

  task automatic t_dup();
    send(0, 3);
    send(0, 3);
    chk(err_dup && !err_range, "R7 repeated flag", {err_dup, err_range}, 2'b10);
    send(5, 3); send(17, 3);
    @(negedge clk);
    chk(done_valid && done_evt == 3 && done_row == MASK3, "R7 row unchanged", done_row, MASK3);
    accept();
  endtask

  task automatic t_range();
    send(20, 4);
    chk(err_range && !err_dup, "R9 source out of range", {err_dup, err_range}, 2'b01);
    send(9, 20);
    chk(err_range, "R9 event beyond window", err_range, 1);
    send(9, 3);
    chk(err_range, "R9 event behind window", err_range, 1);
    send(0, 4); send(5, 4); send(17, 4);
    @(negedge clk);
    chk(done_valid && done_evt == 4 && done_row == MASK3, "R9 nothing stored", done_row, MASK3);
    accept();
  endtask

  task automatic t_empty();
    need_mask = '0;
    send(0, 5); send(5, 5);
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk(!done_valid, "R10 empty mask never offers", done_valid, 0);
    need_mask = NSRC'((1 << 0) | (1 << 5));
    @(negedge clk);
    chk(done_valid && done_evt == 5, "R10 offer once mask set", done_evt, 5);
    accept();
    need_mask = MASK3;
  endtask

  task automatic t_timeout();
    int first;
    int hits;
    logic [NSRC-1:0] seen;
    first = 0; hits = 0; seen = '0;
    tmo_limit = 16'd10;
    send(5, 6);
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (err_miss) begin
        hits++;
        if (first == 0) begin first = k; seen = miss_row; end
      end
    end
    chk(first == 10, "R11 stall pulse cycle", first, 10);
    chk(hits == 1, "R11 single pulse per event", hits, 1);
    chk(seen == NSRC'((1 << 0) | (1 << 17)), "R11 missing sources", seen, (1 << 0) | (1 << 17));
    send(0, 6); send(17, 6);
    @(negedge clk);
    chk(done_valid && done_evt == 6, "R11 late completion offered", done_evt, 6);
    accept();
    tmo_limit = '0;
    hits = 0;
    send(5, 7);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (err_miss) hits++;
    end
    chk(hits == 0, "R11 zero limit disables", hits, 0);
    send(0, 7); send(17, 7);
    @(negedge clk);
    chk(done_valid && done_evt == 7, "R11 event 7 offered", done_evt, 7);
    accept();
  endtask

  task automatic t_wrap();
    need_mask = NSRC'(1);
    for (int n = 8; n <= 4097; n++) begin
      int e;
      e = n % 4096;
      send(0, e);
      if (err_dup || err_range) chk(1'b0, "R6 row cleared after take", {err_dup, err_range}, 0);
      @(negedge clk);
      if (!(done_valid && done_evt == 12'(e)))
        chk(1'b0, "R6 sequence step", done_evt, e);
      accept();
    end
    chk(1'b1, "R6 wrap loop", 0, 0);
    send(0, 2);
    @(negedge clk);
    chk(done_valid && done_evt == 2, "R6 wrapped past 4095", done_evt, 2);
    accept();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_hold();
    t_order();
    t_dup();
    t_range();
    t_empty();
    t_timeout();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule